// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Unit

This unit frees a two-wire bus that a target device has jammed by holding the data line low while the clock line is high. A one-cycle command strobe starts an autonomous hardware sequence. The sequence toggles the clock line with open-drain pulses until the data line reads high, closes with a STOP condition (data rising while clock is high), and then reports the outcome on sticky status outputs.

Each pin is modelled as a sensed input plus an active-high "pull low" enable for an open-drain pad. A separate slow base-clock tick feeds a timeout counter that bounds the whole attempt. The unit reports success, failure, and a distinct data-held-low timeout flag. That flag also implies failure. The clock-high phase of each pulse waits while another device stretches the clock, and the timeout bounds that wait.

Top module: `i2c_bus_unjam`

## Requirements
- R1: After reset both pull-low enables are 0 and all three status outputs are 0.
- R2: A command strobe accepted while idle clears all three status outputs one cycle later and starts a new attempt.
- R3: Each recovery pulse pulls the clock line low for HALF_CYCLES clocks and then releases it for HALF_CYCLES clocks. The data line is sampled in the last cycle of the high phase, and pulsing stops as soon as the sample reads high.
- R4: If the data line still reads low after MAX_PULSES pulses, the unit sets the fail output and releases both lines. No STOP is issued in that case.
- R5: After the data line is released, the unit issues a STOP: clock low, then data pulled low, then clock released, then data released while clock is high. It sets the success output if the data line then reads high.
- R6: If the data line already reads high when the attempt starts, no pulse is issued. The unit performs only the STOP and reports success.
- R7: Base-clock ticks are counted while an attempt runs. When TIMEOUT_TICKS ticks have been counted, the unit sets both fail and the timeout flag and releases both lines, including when the clock line is being held low by another device.
- R8: A command strobe that arrives while an attempt is running has no effect on that attempt.
- R9: Success and fail are never set together. All status outputs hold their value until the next accepted command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recover_req | input | 1 | One-cycle command strobe that starts an attempt |
| base_tick | input | 1 | One-cycle tick from the slow base clock that feeds the timeout |
| scl_in | input | 1 | Sensed level of the clock line |
| sda_in | input | 1 | Sensed level of the data line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| done_ok | output | 1 | Sticky: bus recovered and STOP issued |
| done_fail | output | 1 | Sticky: attempt failed |
| sda_hold_to | output | 1 | Sticky: attempt ended by the base-clock timeout |

## Verification
A model target holds the data line and lets it go on the falling clock edge after a chosen number of rising edges. The bench sweeps that number from zero (bus not stuck) through every count that recovers within the pulse limit, and on to counts that exhaust it. Rising clock edges and STOP events are counted on the bus, which separates early exit, the final permitted pulse and the give-up path. A fast tick rate forces the timeout mid-pulse, and a target that stretches the clock forever forces it in the high phase. A second strobe sent mid-attempt must leave the edge count unchanged.

// File: rtl/i2c_unjam_pkg.sv
package i2c_unjam_pkg;
  typedef enum logic [2:0] {
    UJ_IDLE    = 3'd0,
    UJ_CHECK   = 3'd1,
    UJ_LOW     = 3'd2,
    UJ_HIGH    = 3'd3,
    UJ_P_LOW   = 3'd4,
    UJ_P_HOLD  = 3'd5,
    UJ_P_SETUP = 3'd6,
    UJ_P_REL   = 3'd7
  } uj_state_e;
endpackage

// File: rtl/unjam_phase_timer.sv
module unjam_phase_timer #(
  parameter int HALF_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic phase_end
);
  localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign phase_end = en && (cnt_q == CW'(HALF_CYCLES - 1));

  always_comb begin
    if (!en)            cnt_d = '0;
    else if (phase_end) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/unjam_timeout.sv
module unjam_timeout #(
  parameter int TIMEOUT_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(TIMEOUT_TICKS + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expire = run && tick && (cnt_q == CW'(TIMEOUT_TICKS - 1));

  always_comb begin
    if (clear)                      cnt_d = '0;
    else if (run && tick && !expire) cnt_d = cnt_q + 1'b1;
    else                            cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/unjam_fsm.sv
module unjam_fsm
  import i2c_unjam_pkg::*;
#(
  parameter int MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd,
  input  logic scl_in,
  input  logic sda_in,
  input  logic phase_end,
  input  logic expire,
  output logic timer_en,
  output logic tmo_clear,
  output logic tmo_run,
  output logic scl_oe,
  output logic sda_oe,
  output logic ok,
  output logic fail,
  output logic tmo
);
  localparam int PW = $clog2(MAX_PULSES + 1);

  uj_state_e     state_q, state_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          ok_q, ok_d, fail_q, fail_d, tmo_q, tmo_d;
  logic          scl_q, scl_d, sda_q, sda_d;
  logic          start;

  // the high phase is frozen while another device stretches the clock
  assign timer_en  = (state_q != UJ_IDLE) && (state_q != UJ_CHECK) &&
                     !((state_q == UJ_HIGH) && !scl_in);
  assign tmo_clear = start;
  assign tmo_run   = (state_q != UJ_IDLE);

  always_comb begin
    state_d = state_q;
    pcnt_d  = pcnt_q;
    ok_d    = ok_q;
    fail_d  = fail_q;
    tmo_d   = tmo_q;
    start   = 1'b0;
    case (state_q)
      UJ_IDLE: begin
        if (cmd) begin
          start   = 1'b1;
          state_d = UJ_CHECK;
          pcnt_d  = '0;
          ok_d    = 1'b0;
          fail_d  = 1'b0;
          tmo_d   = 1'b0;
        end
      end
      UJ_CHECK: state_d = sda_in ? UJ_P_LOW : UJ_LOW;
      UJ_LOW:   if (phase_end) state_d = UJ_HIGH;
      UJ_HIGH: begin
        if (phase_end) begin
          pcnt_d = pcnt_q + 1'b1;
          if (sda_in) begin
            state_d = UJ_P_LOW;
          end else if (pcnt_q == PW'(MAX_PULSES - 1)) begin
            state_d = UJ_IDLE;
            fail_d  = 1'b1;
          end else begin
            state_d = UJ_LOW;
          end
        end
      end
      UJ_P_LOW:   if (phase_end) state_d = UJ_P_HOLD;
      UJ_P_HOLD:  if (phase_end) state_d = UJ_P_SETUP;
      UJ_P_SETUP: if (phase_end) state_d = UJ_P_REL;
      UJ_P_REL: begin
        if (phase_end) begin
          state_d = UJ_IDLE;
          if (sda_in) ok_d = 1'b1;
          else        fail_d = 1'b1;
        end
      end
      default: state_d = UJ_IDLE;
    endcase
    if (expire) begin
      state_d = UJ_IDLE;
      ok_d    = 1'b0;
      fail_d  = 1'b1;
      tmo_d   = 1'b1;
    end
    scl_d = state_d inside {UJ_LOW, UJ_P_LOW, UJ_P_HOLD};
    sda_d = state_d inside {UJ_P_HOLD, UJ_P_SETUP};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= UJ_IDLE;
      pcnt_q  <= '0;
      ok_q    <= 1'b0;
      fail_q  <= 1'b0;
      tmo_q   <= 1'b0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pcnt_q  <= pcnt_d;
      ok_q    <= ok_d;
      fail_q  <= fail_d;
      tmo_q   <= tmo_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
    end
  end

  assign scl_oe = scl_q;
  assign sda_oe = sda_q;
  assign ok     = ok_q;
  assign fail   = fail_q;
  assign tmo    = tmo_q;
endmodule

// File: rtl/i2c_bus_unjam.sv
module i2c_bus_unjam #(
  parameter int HALF_CYCLES   = 4,
  parameter int MAX_PULSES    = 9,
  parameter int TIMEOUT_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recover_req,
  input  logic base_tick,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_oe,
  output logic sda_oe,
  output logic done_ok,
  output logic done_fail,
  output logic sda_hold_to
);
  logic timer_en, phase_end, tmo_clear, tmo_run, expire;

  unjam_phase_timer #(.HALF_CYCLES(HALF_CYCLES)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(timer_en), .phase_end(phase_end)
  );

  unjam_timeout #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clear(tmo_clear), .run(tmo_run),
    .tick(base_tick), .expire(expire)
  );

  unjam_fsm #(.MAX_PULSES(MAX_PULSES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd(recover_req), .scl_in(scl_in),
    .sda_in(sda_in), .phase_end(phase_end), .expire(expire),
    .timer_en(timer_en), .tmo_clear(tmo_clear), .tmo_run(tmo_run),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .ok(done_ok), .fail(done_fail),
    .tmo(sda_hold_to)
  );
endmodule

// File: rtl/i2c_bus_unjam_chk.sv
module i2c_bus_unjam_chk (
  input logic clk,
  input logic rst_n,
  input logic recover_req,
  input logic sda_in,
  input logic scl_oe,
  input logic sda_oe,
  input logic done_ok,
  input logic done_fail,
  input logic sda_hold_to
);
  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && done_fail));

  assert_ok_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok && !recover_req) |=> done_ok);

  assert_to_means_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sda_hold_to |-> done_fail);

  assert_released_when_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok || done_fail) |-> (!scl_oe && !sda_oe));

  assert_ok_after_sda_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_ok) |-> $past(sda_in));

  assert_sda_pull_under_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> (scl_oe && $past(scl_oe)));
endmodule

bind i2c_bus_unjam i2c_bus_unjam_chk u_chk (
  .clk(clk), .rst_n(rst_n), .recover_req(recover_req), .sda_in(sda_in),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .done_ok(done_ok),
  .done_fail(done_fail), .sda_hold_to(sda_hold_to)
);

// File: tb/sim_i2c_bus_unjam.sv
module sim_i2c_bus_unjam;
  localparam int PER  = 4;
  localparam int HALF = 4;
  localparam int MAXP = 9;
  localparam int TOT  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recover_req = 1'b0;
  logic base_tick = 1'b0;
  logic scl_in, sda_in, scl_oe, sda_oe, done_ok, done_fail, sda_hold_to;
  logic slave_hold = 1'b0;
  logic stretch = 1'b0;

  int n_checks = 0, n_fail = 0, cyc = 0;
  int rises = 0, stops = 0, k_target = 0, tick_div = 8, tcnt = 0;
  int first_low = -1, first_high = -1;
  longint t_fall = 0, t_rise = 0;
  bit finished = 0;

  always #(PER/2) clk = ~clk;

  assign scl_in = !(scl_oe || stretch);
  assign sda_in = !(sda_oe || slave_hold);

  i2c_bus_unjam #(.HALF_CYCLES(HALF), .MAX_PULSES(MAXP), .TIMEOUT_TICKS(TOT)) u0 (
    .clk(clk), .rst_n(rst_n), .recover_req(recover_req), .base_tick(base_tick),
    .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .done_ok(done_ok), .done_fail(done_fail), .sda_hold_to(sda_hold_to)
  );

  always @(negedge clk) begin
    if (tcnt >= tick_div - 1) begin tcnt <= 0; base_tick <= 1'b1; end
    else begin tcnt <= tcnt + 1; base_tick <= 1'b0; end
  end

  // bus observer and model target
  always @(posedge scl_in) begin
    rises = rises + 1;
    t_rise = longint'($time);
    if (rises == 1) first_low = int'((longint'($time) - t_fall) / PER);
  end

  always @(negedge scl_in) begin
    if (rises == 1) first_high = int'((longint'($time) - t_rise) / PER);
    t_fall = longint'($time);
    if (slave_hold && rises >= k_target) slave_hold = 1'b0;
  end

  always @(posedge sda_in) if (scl_in) stops = stops + 1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks = n_checks + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input int k, input int div, input bit hold_scl, input bit extra_cmd);
    slave_hold = 1'b0;
    stretch = 1'b0;
    repeat (3) @(negedge clk);
    tick_div = div;
    k_target = k;
    slave_hold = (k > 0);
    stretch = hold_scl;
    #1;
    rises = 0; stops = 0; first_low = -1; first_high = -1;
    @(negedge clk) recover_req = 1'b1;
    @(negedge clk) recover_req = 1'b0;
    if (extra_cmd) begin
      repeat (12) @(negedge clk);
      recover_req = 1'b1;
      @(negedge clk) recover_req = 1'b0;
    end
    for (int i = 0; i < 3000 && !(done_ok || done_fail); i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "scl_oe in reset", int'(scl_oe), 0);
    chk("R1", "sda_oe in reset", int'(sda_oe), 0);
    chk("R1", "flags in reset", int'({done_ok, done_fail, sda_hold_to}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "flags after reset", int'({done_ok, done_fail, sda_hold_to}), 0);

    // sweep of release points
    for (int k = 0; k <= 11; k++) begin
      int exp_ok, exp_rises;
      run_case(k, 8, 1'b0, 1'b0);
      exp_ok    = (k <= MAXP - 1) ? 1 : 0;
      exp_rises = (k == 0) ? 1 : ((k <= MAXP - 1) ? k + 2 : MAXP);
      if (k == 0) chk("R6", "ok with free bus", int'(done_ok), 1);
      else        chk("R5", "ok", int'(done_ok), exp_ok);
      chk("R4", "fail", int'(done_fail), 1 - exp_ok);
      chk("R7", "no timeout", int'(sda_hold_to), 0);
      chk("R3", "clock rises", rises, exp_rises);
      chk("R5", "stop count", stops, exp_ok);
      chk("R4", "lines released", int'({scl_oe, sda_oe}), 0);
      if (k == 2) begin
        chk("R3", "low phase clocks", first_low, HALF);
        chk("R3", "high phase clocks", first_high, HALF);
      end
    end

    // R7: timeout with fast ticks
    run_case(11, 1, 1'b0, 1'b0);
    chk("R7", "fail on timeout", int'(done_fail), 1);
    chk("R7", "timeout flag", int'(sda_hold_to), 1);
    chk("R9", "ok clear on timeout", int'(done_ok), 0);
    chk("R7", "pulses cut short", int'(rises < MAXP), 1);
    chk("R7", "released on timeout", int'({scl_oe, sda_oe}), 0);

    // R7: clock stretched forever
    run_case(11, 8, 1'b1, 1'b0);
    chk("R7", "stretch timeout flag", int'(sda_hold_to), 1);
    chk("R7", "stretch fail", int'(done_fail), 1);
    chk("R7", "stretch rises", rises, 0);

    // R8: strobe during attempt ignored
    run_case(3, 8, 1'b0, 1'b1);
    chk("R8", "ok despite strobe", int'(done_ok), 1);
    chk("R8", "rises despite strobe", rises, 5);
    chk("R8", "single stop", stops, 1);

    // R2 and R9: flags cleared by new command, held while idle
    run_case(11, 1, 1'b0, 1'b0);
    run_case(1, 8, 1'b0, 1'b0);
    chk("R2", "fail cleared", int'(done_fail), 0);
    chk("R2", "timeout cleared", int'(sda_hold_to), 0);
    chk("R2", "ok set", int'(done_ok), 1);
    repeat (50) @(negedge clk);
    chk("R9", "ok held", int'(done_ok), 1);
    chk("R9", "fail still clear", int'(done_fail), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule